// File: doc/BRIEF.md
# Cyclic (15,7) Check-Bit Encoder

This block turns a 7-bit information word into the 15-bit systematic codeword of a cyclic code with minimum distance 5. The codeword is read by a one-step majority-logic corrector. The seven information bits pass unchanged into codeword positions 0 to 6. Positions 7 to 14 carry eight check bits, and each check bit is the XOR of a fixed subset of the information bits. The subsets are not written by hand. Package functions derive them at elaboration from the generator polynomial g(x) = 1 + x^4 + x^6 + x^7 + x^8, with codeword position j taken as the coefficient of x^j. In that ordering every codeword, and every cyclic rotation of one, gives zero on the corrector's four orthogonal check sums on bit 14.

The encoding is a single level of XOR trees. A parameter selects whether the result is registered: with a register the codeword arrives one cycle after the input strobe, and without one the output is combinational. A controller instantiates one encoder per data cluster, or shares one across clusters, presenting a word together with `enc_valid`. Decoding and storage belong to other blocks.

Top module: `cyc15_encoder`

## Requirements
- R1: While `rst_n` is low, and on the first sampling point after it is released with no strobe, `cw_valid` is 0 and `cw_data` is all zeros.
- R2: Codeword bit m (m = 0..6) equals information bit `info_bits[m]`.
- R3: Reading `cw_data[j]` as the coefficient of x^j, the codeword polynomial leaves remainder zero when divided by 1 + x^4 + x^6 + x^7 + x^8. The eight check bits sit in positions 7..14.
- R4: Each of the four check sums over the position sets {3,11,12,14}, {1,5,13,14}, {0,2,6,14} and {7,8,10,14} XORs to 0 for every codeword.
- R5: Every one of the 15 cyclic rotations of a codeword also gives zero on all four check sums of R4.
- R6: Every nonzero codeword has at least five bits set.
- R7: After any one or two bits of a codeword are flipped, the corrector restores the codeword exactly. The corrector checks bit 14 against the four sums of R4, inverts bit 14 when at least three sums are 1, rotates the word by one position, and repeats this for 15 steps.
- R8: With `REG_OUT` = 1, a word presented with `enc_valid` high at a rising edge appears on `cw_data` after that edge, with `cw_valid` high for exactly as many cycles as `enc_valid` was high.
- R9: With `REG_OUT` = 1, `cw_data` holds its last value on every edge where `enc_valid` is low, whatever `info_bits` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_valid | input | 1 | Strobe marking `info_bits` as a word to encode |
| info_bits | input | 7 | Information word |
| cw_valid | output | 1 | Codeword on `cw_data` is fresh |
| cw_data | output | 15 | Systematic codeword, information in bits 0..6, checks in bits 7..14 |

## Verification
The assertions assume that `enc_valid` and `info_bits` are known values whenever the block is out of reset. They also assume both inputs change only between edges, so a word strobed at one edge is the word the register captured. The stimulus meets this by changing both inputs only on falling clock edges. It walks `info_bits` through all 128 values and uses only fully defined patterns, including while the strobe is low. The error patterns for the corrector are applied in the bench to captured codewords and never reach the block's inputs.

// File: rtl/cyc15_code_pkg.sv
package cyc15_code_pkg;

    localparam int CW_N   = 15;
    localparam int INFO_K = 7;
    localparam int CHK_M  = CW_N - INFO_K;

    // Generator polynomial, bit d = coefficient of x^d: 1 + x^4 + x^6 + x^7 + x^8
    localparam logic [CHK_M:0] GEN_POLY = 9'b1_1101_0001;

    // Orthogonal check sums of the corrector, all meeting on bit 14
    localparam logic [CW_N-1:0] ORTH_A = 15'b101_1000_0000_1000; // 3,11,12,14
    localparam logic [CW_N-1:0] ORTH_B = 15'b110_0000_0010_0010; // 1,5,13,14
    localparam logic [CW_N-1:0] ORTH_C = 15'b100_0000_0100_0101; // 0,2,6,14
    localparam logic [CW_N-1:0] ORTH_D = 15'b100_0101_1000_0000; // 7,8,10,14

    // Parity polynomial h(x) = (x^N + 1) / g(x), found by long division
    function automatic logic [INFO_K:0] parity_poly();
        logic [CW_N:0]   rem;
        logic [CW_N:0]   gext;
        logic [INFO_K:0] quo;
        rem        = '0;
        rem[CW_N]  = 1'b1;
        rem[0]     = 1'b1;
        gext       = {{(CW_N-CHK_M){1'b0}}, GEN_POLY};
        quo        = '0;
        for (int d = CW_N; d >= CHK_M; d--) begin
            if (rem[d]) begin
                quo[d-CHK_M] = 1'b1;
                rem          = rem ^ (gext << (d - CHK_M));
            end
        end
        return quo;
    endfunction

    // For each codeword position, the set of information bits it XORs.
    // Positions below K are identity; higher ones follow c_j = sum h_s c_(j-s).
    function automatic logic [CW_N*INFO_K-1:0] position_masks();
        logic [INFO_K:0]         hp;
        logic [CW_N*INFO_K-1:0]  m;
        logic [INFO_K-1:0]       acc;
        hp = parity_poly();
        m  = '0;
        for (int j = 0; j < INFO_K; j++) begin
            acc    = '0;
            acc[j] = 1'b1;
            m[j*INFO_K +: INFO_K] = acc;
        end
        for (int j = INFO_K; j < CW_N; j++) begin
            acc = '0;
            for (int s = 1; s <= INFO_K; s++) begin
                if (hp[s]) acc = acc ^ m[(j-s)*INFO_K +: INFO_K];
            end
            m[j*INFO_K +: INFO_K] = acc;
        end
        return m;
    endfunction

endpackage

// File: rtl/cyc15_check_xor.sv
module cyc15_check_xor
    import cyc15_code_pkg::*;
(
    input  logic [INFO_K-1:0] info_in,
    output logic [CHK_M-1:0]  check_out
);

    localparam logic [CW_N*INFO_K-1:0] MASKS = position_masks();

    for (genvar c = 0; c < CHK_M; c++) begin : g_chk
        localparam logic [INFO_K-1:0] SEL = MASKS[(INFO_K+c)*INFO_K +: INFO_K];
        assign check_out[c] = ^(info_in & SEL);
    end

endmodule

// File: rtl/cyc15_out_stage.sv
module cyc15_out_stage #(
    parameter int W       = 15,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    if (REG_OUT) begin : g_reg
        logic         valid_q;
        logic [W-1:0] data_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                data_q  <= '0;
            end else begin
                valid_q <= in_valid;
                if (in_valid) data_q <= in_data;
            end
        end

        assign out_valid = valid_q;
        assign out_data  = data_q;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign out_valid  = in_valid;
        assign out_data   = in_data;
    end

endmodule

// File: rtl/cyc15_encoder.sv
module cyc15_encoder
    import cyc15_code_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid,
    input  logic [INFO_K-1:0] info_bits,
    output logic              cw_valid,
    output logic [CW_N-1:0]   cw_data
);

    logic [CHK_M-1:0] check_bits;
    logic [CW_N-1:0]  cw_next;

    cyc15_check_xor u_xor (
        .info_in   (info_bits),
        .check_out (check_bits)
    );

    assign cw_next = {check_bits, info_bits};

    cyc15_out_stage #(
        .W       (CW_N),
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (enc_valid),
        .in_data   (cw_next),
        .out_valid (cw_valid),
        .out_data  (cw_data)
    );

endmodule

// File: rtl/cyc15_encoder_chk.sv
module cyc15_encoder_chk
    import cyc15_code_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enc_valid,
    input logic [INFO_K-1:0] info_bits,
    input logic              cw_valid,
    input logic [CW_N-1:0]   cw_data
);

    logic [CW_N-1:0] cw_rot;
    assign cw_rot = {cw_data[CW_N-2:0], cw_data[CW_N-1]};

    assert_orth_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |-> ((^(cw_data & ORTH_A)) == 1'b0 && (^(cw_data & ORTH_B)) == 1'b0 &&
                      (^(cw_data & ORTH_C)) == 1'b0 && (^(cw_data & ORTH_D)) == 1'b0));

    assert_rot_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |-> ((^(cw_rot & ORTH_A)) == 1'b0 && (^(cw_rot & ORTH_B)) == 1'b0 &&
                      (^(cw_rot & ORTH_C)) == 1'b0 && (^(cw_rot & ORTH_D)) == 1'b0));

    assert_min_weight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |-> ($countones(cw_data) == 0 || $countones(cw_data) >= 5));

    if (REG_OUT) begin : g_reg_chk
        assert_systematic_R2: assert property (@(posedge clk) disable iff (!rst_n)
            enc_valid |=> (cw_data[INFO_K-1:0] == $past(info_bits)));

        assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            enc_valid |=> cw_valid);

        assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !enc_valid |=> !cw_valid);

        assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !enc_valid |=> $stable(cw_data));
    end else begin : g_comb_chk
        assert_systematic_R2: assert property (@(posedge clk) disable iff (!rst_n)
            enc_valid |-> (cw_data[INFO_K-1:0] == info_bits));
    end

endmodule

bind cyc15_encoder cyc15_encoder_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enc_valid (enc_valid),
    .info_bits (info_bits),
    .cw_valid  (cw_valid),
    .cw_data   (cw_data)
);

// File: tb/tb_cyc15_encoder.sv
module tb_cyc15_encoder;

    logic        clk;
    logic        rst_n;
    logic        enc_valid;
    logic [6:0]  info_bits;
    logic        cw_valid;
    logic [14:0] cw_data;

    int n_checks = 0;
    int n_fail   = 0;

    cyc15_encoder #(.REG_OUT(1'b1)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enc_valid (enc_valid),
        .info_bits (info_bits),
        .cw_valid  (cw_valid),
        .cw_data   (cw_data)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [14:0] act, input logic [14:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Remainder of codeword polynomial modulo 1 + x^4 + x^6 + x^7 + x^8
    function automatic logic [14:0] poly_rem(input logic [14:0] c);
        logic [14:0] r;
        r = c;
        for (int d = 14; d >= 8; d--) begin
            if (r[d]) r = r ^ (15'h01D1 << (d - 8));
        end
        return r;
    endfunction

    function automatic logic [3:0] sums(input logic [14:0] c);
        logic [3:0] s;
        s[0] = c[3] ^ c[11] ^ c[12] ^ c[14];
        s[1] = c[1] ^ c[5]  ^ c[13] ^ c[14];
        s[2] = c[0] ^ c[2]  ^ c[6]  ^ c[14];
        s[3] = c[7] ^ c[8]  ^ c[10] ^ c[14];
        return s;
    endfunction

    function automatic logic [14:0] rotl(input logic [14:0] c);
        return {c[13:0], c[14]};
    endfunction

    // One-step majority corrector: 15 steps, bit 14 under test each step
    function automatic logic [14:0] correct(input logic [14:0] c);
        logic [14:0] w;
        logic [3:0]  s;
        w = c;
        for (int k = 0; k < 15; k++) begin
            s = sums(w);
            if ((int'(s[0]) + int'(s[1]) + int'(s[2]) + int'(s[3])) >= 3) w[14] = ~w[14];
            w = rotl(w);
        end
        return w;
    endfunction

    initial begin
        logic [14:0] held;
        logic [14:0] r;
        bit          rot_ok;
        int          bad;
        int          w;

        rst_n     = 1'b0;
        enc_valid = 1'b0;
        info_bits = 7'h55;
        #35;
        check(cw_valid == 1'b0, "R1 valid in reset", {14'd0, cw_valid}, 15'd0);
        check(cw_data == 15'd0, "R1 data in reset", cw_data, 15'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cw_valid == 1'b0 && cw_data == 15'd0, "R1 after release", cw_data, 15'd0);

        // Exhaustive sweep with a continuous strobe
        enc_valid = 1'b1;
        for (int v = 0; v < 128; v++) begin
            info_bits = 7'(v);
            @(negedge clk);
            check(cw_valid == 1'b1, "R8 valid one cycle later", {14'd0, cw_valid}, 15'd1);
            check(cw_data[6:0] == 7'(v), "R2 systematic bits", {8'd0, cw_data[6:0]}, 15'(v));
            r = poly_rem(cw_data);
            check(r == 15'd0, "R3 remainder by generator", r, 15'd0);
            check(sums(cw_data) == 4'd0, "R4 check sums", {11'd0, sums(cw_data)}, 15'd0);
            rot_ok = 1'b1;
            r = cw_data;
            for (int k = 0; k < 15; k++) begin
                r = rotl(r);
                if (sums(r) != 4'd0) rot_ok = 1'b0;
            end
            check(rot_ok, "R5 all rotations", cw_data, cw_data);
            w = $countones(cw_data);
            check(v == 0 ? w == 0 : w >= 5, "R6 weight", 15'(w), 15'd5);
            bad = 0;
            for (int a = 0; a < 15; a++) begin
                if (correct(cw_data ^ (15'd1 << a)) != cw_data) bad++;
                for (int b = a + 1; b < 15; b++) begin
                    if (correct(cw_data ^ (15'd1 << a) ^ (15'd1 << b)) != cw_data) bad++;
                end
            end
            check(bad == 0, "R7 one and two bit repair", 15'(bad), 15'd0);
        end

        // Strobe low: valid drops, data holds while info changes
        enc_valid = 1'b0;
        held      = cw_data;
        info_bits = 7'h2A;
        @(negedge clk);
        check(cw_valid == 1'b0, "R8 valid drops", {14'd0, cw_valid}, 15'd0);
        check(cw_data == held, "R9 hold first cycle", cw_data, held);
        info_bits = 7'h15;
        @(negedge clk);
        info_bits = 7'h00;
        @(negedge clk);
        check(cw_data == held, "R9 hold after changes", cw_data, held);

        // Single-cycle strobe of a fresh word
        enc_valid = 1'b1;
        info_bits = 7'h01;
        @(negedge clk);
        enc_valid = 1'b0;
        info_bits = 7'h7F;
        check(cw_valid == 1'b1 && cw_data[6:0] == 7'h01, "R8 single strobe", cw_data, 15'h0001);
        @(negedge clk);
        check(cw_valid == 1'b0 && cw_data[6:0] == 7'h01, "R9 single strobe hold", cw_data, 15'h0001);

        // Reset in mid-stream
        enc_valid = 1'b1;
        info_bits = 7'h33;
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check(cw_valid == 1'b0 && cw_data == 15'd0, "R1 reset mid-stream", cw_data, 15'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule